// File: doc/BRIEF.md
# Timer Compare Channel Output Controller

This block is an up-counting timer with two compare channels, built for the output-compare path. A counter runs from zero up to a programmable period while its run input is high, then reloads to zero and raises an overflow event. Each channel compares the counter with its own active compare value. It drives its output pin according to a 3-bit output-control code: disconnected, set on match, clear on match, toggle on match, forced low, forced high, or one of two PWM polarities.

Software reaches the block through a single-cycle register port with a combinational read path. Compare values can be written straight into the active register, or staged in a shadow register that is transferred on the next overflow. A write-only event register lets software inject an overflow, a per-channel compare event or a trigger event. Sticky flags for overflow, each channel and the trigger are brought out as pins and cleared by writing ones.

Top module: `tmr_cmp_out`

## Requirements
- R1: While `run_i` is high the counter rises by one per clock. On a clock where it is at or above the period it reloads to 0 and sets the overflow flag. While `run_i` is low it holds. Address 1 holds the period (reset 0xFFFF) and address 6 reads the counter (reset 0).
- R2: Address 0 holds the channel modes: channel 0 in bits 7:0 and channel 1 in bits 15:8. Each byte is {reserved, code[2:0], buffer enable, immediate enable, direction[1:0]}. With code 001 a match sets the output's level register high, and with code 010 a match clears it. A match is a running clock with direction 00 and counter equal to the active compare value, and it takes effect at that clock edge.
- R3: With code 011 each match inverts the output level.
- R4: Code 100 drives the output low and code 101 drives it high, whatever the counter is doing. Either code also loads that level into the level register.
- R5: Code 110 drives the output high while the counter is below the compare value, and low otherwise. Code 111 gives the inverse.
- R6: Code 000 drives the output low. A direction other than 00 marks the channel as an input: its output stays low and matches do not set its flag.
- R7: Addresses 2 and 3 hold the compare values for channels 0 and 1 and read back the active value. With buffer enable clear, a write updates the active value at once. With it set, the write goes to a shadow register that is copied to the active value on the next overflow event.
- R8: Address 4 is the write-only event register: bit 0 is overflow, bit 1 is channel 0, bit 2 is channel 1 and bit 6 is trigger. It always reads 0, and a 0 written to a bit has no effect.
- R9: A software overflow event resets the counter to 0, sets the overflow flag and performs the shadow-to-active transfer.
- R10: A software channel event sets that channel's flag. When the channel's immediate enable is set and the channel is an output, the event also acts as a match on the output level.
- R11: A software trigger event sets the trigger flag.
- R12: Address 5 reads the flags in the same bit positions as the event register and clears each flag whose bit is written as 1. The other flags are kept.
- R13: After reset all modes, compare values and flags are zero and every channel output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Counter enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| ch_out | output | 2 | Channel outputs, bit i for channel i |
| ovf_flag | output | 1 | Sticky overflow flag |
| ch_flag | output | 2 | Sticky per-channel compare flags |
| trg_flag | output | 1 | Sticky trigger flag |

## Verification
The bench builds the block with its default 16-bit counter and programs a period of 9. Wraps, repeated matches within one run and shadow transfers on a natural overflow therefore all happen within a few dozen cycles. A 4-bit compare value and a step count of up to 31 cover matches before, at and after the stopping point. They also cover a toggle that fires twice across a wrap, and a PWM compare of zero that never goes high.

// File: rtl/tmr_pkg.sv
// Package: shared register map, mode layout and event bit positions for the
// timer compare output controller. Assumes two channels and a 16-bit bus.
package tmr_pkg;
    localparam int CH_N   = 2;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;
    localparam int MODE_W = 8;

    localparam int A_MODE   = 0;
    localparam int A_PERIOD = 1;
    localparam int A_CMP0   = 2;
    localparam int A_EVT    = 4;
    localparam int A_FLAGS  = 5;
    localparam int A_COUNT  = 6;

    localparam int EV_OVF = 0;
    localparam int EV_CH0 = 1;
    localparam int EV_TRG = 6;

    typedef enum logic [2:0] {
        OC_OFF  = 3'd0,
        OC_SET  = 3'd1,
        OC_CLR  = 3'd2,
        OC_TOG  = 3'd3,
        OC_LOW  = 3'd4,
        OC_HIGH = 3'd5,
        OC_PWMA = 3'd6,
        OC_PWMB = 3'd7
    } oc_t;

    localparam logic [1:0] DIR_OUT = 2'b00;

    typedef struct packed {
        oc_t        oc;
        logic       buf_en;
        logic       imm_en;
        logic [1:0] dir;
    } ch_mode_t;
endpackage

// File: rtl/tmr_counter.sv
// Module: up counter with period reload. Counts while run is high, reloads
// to zero at or above the period, and clears on a software overflow event.
// Assumes the period register is stable relative to the count.
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sw_ovf,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_evt
);
    logic wrap;

    // Detect the natural reload point.
    always_comb wrap = run && (cnt >= period);

    // Combine natural and software overflow into one event.
    always_comb ovf_evt = wrap || sw_ovf;

    // Advance, reload or clear the count.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (ovf_evt)  cnt <= '0;
        else if (run)      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tmr_chan_out.sv
// Module: one compare channel. Detects matches, keeps the output level
// register and selects the pin drive from the 3-bit output-control code.
// Assumes the compare value is the active (not shadow) one.
module tmr_chan_out
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sw_ch,
    input  ch_mode_t         mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             ch_out,
    output logic             match_evt
);
    logic is_out;
    logic act;
    logic below;
    logic lvl_q;

    // Decode direction and compare conditions.
    always_comb begin
        is_out    = (mode.dir == DIR_OUT);
        match_evt = run && is_out && (cnt == cmp);
        act       = match_evt || (sw_ch && mode.imm_en && is_out);
        below     = (cnt < cmp);
    end

    // Update the level register on matches and forced codes.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else begin
            case (mode.oc)
                OC_SET:  if (act) lvl_q <= 1'b1;
                OC_CLR:  if (act) lvl_q <= 1'b0;
                OC_TOG:  if (act) lvl_q <= ~lvl_q;
                OC_LOW:  lvl_q <= 1'b0;
                OC_HIGH: lvl_q <= 1'b1;
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    // Select the pin drive from the code.
    always_comb begin
        if (!is_out) ch_out = 1'b0;
        else begin
            case (mode.oc)
                OC_OFF:  ch_out = 1'b0;
                OC_LOW:  ch_out = 1'b0;
                OC_HIGH: ch_out = 1'b1;
                OC_PWMA: ch_out = below;
                OC_PWMB: ch_out = ~below;
                default: ch_out = lvl_q;
            endcase
        end
    end
endmodule

// File: rtl/tmr_regs.sv
// Module: register file. Holds modes, period and compare values (with
// shadows), decodes write-only software events and keeps the sticky flags.
// Assumes CNT_W does not exceed the 16-bit data bus.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic                   ovf_evt,
    input  logic [CH_N-1:0]        match_evt,
    input  logic [CNT_W-1:0]       cnt,
    output ch_mode_t               mode [CH_N],
    output logic [CNT_W-1:0]       period,
    output logic [CNT_W-1:0]       cmp_act [CH_N],
    output logic                   sw_ovf,
    output logic [CH_N-1:0]        sw_ch,
    output logic [DATA_W-1:0]      rdata,
    output logic                   ovf_flag,
    output logic [CH_N-1:0]        ch_flag,
    output logic                   trg_flag
);
    logic                   evt_wr;
    logic                   flg_wr;
    logic                   sw_trg;
    logic [CNT_W-1:0]       cmp_shd [CH_N];
    logic [DATA_W-1:0]      mode_raw;
    logic [DATA_W-1:0]      flag_word;

    // Decode event-register and flag-register writes.
    always_comb begin
        evt_wr = wr_en && (addr == ADDR_W'(A_EVT));
        flg_wr = wr_en && (addr == ADDR_W'(A_FLAGS));
        sw_ovf = evt_wr && wdata[EV_OVF];
        sw_trg = evt_wr && wdata[EV_TRG];
    end

    // Hold mode and period registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_raw <= '0;
            period   <= '1;
        end else if (wr_en) begin
            if (addr == ADDR_W'(A_MODE))   mode_raw <= wdata;
            if (addr == ADDR_W'(A_PERIOD)) period   <= wdata[CNT_W-1:0];
        end
    end

    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        logic cmp_wr;

        // Map the mode byte and per-channel software event.
        always_comb begin
            mode[i]  = ch_mode_t'(mode_raw[i*MODE_W +: MODE_W-1]);
            sw_ch[i] = evt_wr && wdata[EV_CH0+i];
            cmp_wr   = wr_en && (addr == ADDR_W'(A_CMP0 + i));
        end

        // Stage compare writes and transfer on overflow.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_shd[i] <= '0;
                cmp_act[i] <= '0;
            end else begin
                if (cmp_wr) cmp_shd[i] <= wdata[CNT_W-1:0];
                if (cmp_wr && !mode[i].buf_en)      cmp_act[i] <= wdata[CNT_W-1:0];
                else if (ovf_evt && mode[i].buf_en) cmp_act[i] <= cmp_shd[i];
            end
        end

        // Keep the sticky channel flag; a set beats a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) ch_flag[i] <= 1'b0;
            else if (match_evt[i] || sw_ch[i]) ch_flag[i] <= 1'b1;
            else if (flg_wr && wdata[EV_CH0+i]) ch_flag[i] <= 1'b0;
        end
    end

    // Keep the sticky overflow and trigger flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            trg_flag <= 1'b0;
        end else begin
            if (ovf_evt)                     ovf_flag <= 1'b1;
            else if (flg_wr && wdata[EV_OVF]) ovf_flag <= 1'b0;
            if (sw_trg)                      trg_flag <= 1'b1;
            else if (flg_wr && wdata[EV_TRG]) trg_flag <= 1'b0;
        end
    end

    // Assemble the flag word in event-register bit positions.
    always_comb begin
        flag_word = '0;
        flag_word[EV_OVF] = ovf_flag;
        flag_word[EV_TRG] = trg_flag;
        for (int i = 0; i < CH_N; i++) flag_word[EV_CH0+i] = ch_flag[i];
    end

    // Drive the read mux; the event register reads as zero.
    always_comb begin
        rdata = '0;
        case (int'(addr))
            A_MODE:   rdata = mode_raw & 16'h7F7F;
            A_PERIOD: rdata = DATA_W'(period);
            A_CMP0:   rdata = DATA_W'(cmp_act[0]);
            A_CMP0+1: rdata = DATA_W'(cmp_act[1]);
            A_FLAGS:  rdata = flag_word;
            A_COUNT:  rdata = DATA_W'(cnt);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_cmp_out.sv
// Module: top of the timer compare output controller. Wires the register
// file, the counter and one output channel per compare unit.
// Assumes a single clock and synchronous active-low reset.
module tmr_cmp_out
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic [1:0]        ch_out,
    output logic              ovf_flag,
    output logic [1:0]        ch_flag,
    output logic              trg_flag
);
    ch_mode_t          mode [CH_N];
    logic [CNT_W-1:0]  period_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cmp_act [CH_N];
    logic              sw_ovf;
    logic [CH_N-1:0]   sw_ch;
    logic              ovf_evt;
    logic [CH_N-1:0]   match_evt;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .ovf_evt(ovf_evt), .match_evt(match_evt), .cnt(cnt_q),
        .mode(mode), .period(period_q), .cmp_act(cmp_act),
        .sw_ovf(sw_ovf), .sw_ch(sw_ch), .rdata(rdata),
        .ovf_flag(ovf_flag), .ch_flag(ch_flag), .trg_flag(trg_flag)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run_i), .sw_ovf(sw_ovf),
        .period(period_q), .cnt(cnt_q), .ovf_evt(ovf_evt)
    );

    for (genvar i = 0; i < CH_N; i++) begin : g_out
        tmr_chan_out #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .run(run_i), .sw_ch(sw_ch[i]),
            .mode(mode[i]), .cnt(cnt_q), .cmp(cmp_act[i]),
            .ch_out(ch_out[i]), .match_evt(match_evt[i])
        );
    end
endmodule

// File: rtl/tmr_cmp_out_chk.sv
// Module: property checker for the timer compare output controller, bound
// to the top. Watches the ports plus the count and period registers.
module tmr_cmp_out_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_i,
    input logic             wr_en,
    input logic [2:0]       addr,
    input logic [15:0]      wdata,
    input logic [15:0]      rdata,
    input logic             ovf_flag,
    input logic             trg_flag,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] period
);
    logic ev_wr;
    logic sw_ovf;
    always_comb begin
        ev_wr  = wr_en && (addr == 3'd4);
        sw_ovf = ev_wr && wdata[0];
    end

    // R1: reload at or above the period.
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cnt >= period && !sw_ovf) |=> (cnt == '0));
    // R1: increment below the period.
    p_count_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cnt < period && !sw_ovf) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
    // R1: hold when stopped.
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !sw_ovf) |=> $stable(cnt));
    // R9: software overflow clears the count and flags it.
    p_sw_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ovf |=> (cnt == '0 && ovf_flag));
    // R8: event register reads as zero.
    p_evt_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd4) |-> (rdata == 16'h0));
    // R11: software trigger sets the trigger flag.
    p_trg_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wr && wdata[6]) |=> trg_flag);
    // R12: overflow flag stays set unless cleared.
    p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(wr_en && addr == 3'd5 && wdata[0])) |=> ovf_flag);
endmodule

bind tmr_cmp_out tmr_cmp_out_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ovf_flag(ovf_flag), .trg_flag(trg_flag),
    .cnt(cnt_q), .period(period_q)
);

// File: tb/tb_tmr_cmp_out.sv
module tb_tmr_cmp_out;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  ch_out;
    logic        ovf_flag;
    logic [1:0]  ch_flag;
    logic        trg_flag;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_cmp_out dut (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ch_out(ch_out), .ovf_flag(ovf_flag),
        .ch_flag(ch_flag), .trg_flag(trg_flag)
    );

    localparam logic [2:0] A_MODE = 3'd0, A_PER = 3'd1, A_C0 = 3'd2,
                           A_EVT = 3'd4, A_FLG = 3'd5, A_CNT = 3'd6;

    typedef struct packed {
        logic       init;
        logic [2:0] code;
        logic [3:0] cmp;
        logic [4:0] steps;
        logic       exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd1, 4'd3, 5'd5,  1'b1},  // R2 set after match
        '{1'b0, 3'd1, 4'd6, 5'd5,  1'b0},  // R2 match not reached
        '{1'b1, 3'd2, 4'd3, 5'd5,  1'b0},  // R2 clear after match
        '{1'b1, 3'd2, 4'd7, 5'd5,  1'b1},  // R2 clear not reached
        '{1'b0, 3'd3, 4'd2, 5'd4,  1'b1},  // R3 toggle once from low
        '{1'b1, 3'd3, 4'd2, 5'd4,  1'b0},  // R3 toggle once from high
        '{1'b0, 3'd3, 4'd2, 5'd13, 1'b0},  // R3 toggle twice across wrap
        '{1'b0, 3'd6, 4'd4, 5'd3,  1'b1},  // R5 mode A below
        '{1'b0, 3'd6, 4'd4, 5'd4,  1'b0},  // R5 mode A at compare
        '{1'b0, 3'd7, 4'd4, 5'd3,  1'b0},  // R5 mode B below
        '{1'b0, 3'd7, 4'd4, 5'd6,  1'b1},  // R5 mode B above
        '{1'b0, 3'd6, 4'd0, 5'd2,  1'b0},  // R5 compare zero never high
        '{1'b1, 3'd4, 4'd3, 5'd5,  1'b0},  // R4 forced low
        '{1'b1, 3'd0, 4'd0, 5'd3,  1'b0}   // R6 disconnected
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic run_steps(input int n);
        @(negedge clk);
        run_i = 1'b1;
        repeat (n) @(negedge clk);
        run_i = 1'b0;
    endtask

    function automatic logic [15:0] mbyte(input logic [2:0] oc, input logic b, input logic im, input logic [1:0] dir);
        return {8'h00, 1'b0, oc, b, im, dir};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] r;
        logic [15:0] c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        rd(A_PER, r);  check("R13 period reset", r, 16'hFFFF);
        rd(A_CNT, r);  check("R13 count reset", r, 16'h0);
        rd(A_MODE, r); check("R13 mode reset", r, 16'h0);
        rd(A_C0, r);   check("R13 cmp reset", r, 16'h0);
        rd(A_FLG, r);  check("R13 flags reset", r, 16'h0);
        check("R13 outputs reset", {14'h0, ch_out}, 16'h0);

        wr(A_PER, 16'd9);

        // Vector table: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            wr(A_MODE, mbyte(VEC[i].init ? 3'd5 : 3'd4, 1'b0, 1'b0, 2'b00));
            wr(A_EVT, 16'h0001);
            wr(A_C0, {12'h0, VEC[i].cmp});
            wr(A_MODE, mbyte(VEC[i].code, 1'b0, 1'b0, 2'b00));
            run_steps(int'(VEC[i].steps));
            #1;
            check($sformatf("R2-6 vector %0d", i), {15'h0, ch_out[0]}, {15'h0, VEC[i].exp});
        end

        // R4 forced high
        wr(A_MODE, mbyte(3'd5, 1'b0, 1'b0, 2'b00));
        #1; check("R4 forced high", {15'h0, ch_out[0]}, 16'h1);

        // R1 count and wrap
        wr(A_MODE, 16'h0);
        wr(A_EVT, 16'h0001);
        wr(A_FLG, 16'hFFFF);
        run_steps(9);
        rd(A_CNT, r); check("R1 count at period", r, 16'd9);
        check("R1 no overflow yet", {15'h0, ovf_flag}, 16'h0);
        run_steps(1);
        rd(A_CNT, r); check("R1 wrapped", r, 16'd0);
        check("R1 overflow flag", {15'h0, ovf_flag}, 16'h1);

        // R9 software overflow
        run_steps(4);
        wr(A_FLG, 16'hFFFF);
        wr(A_EVT, 16'h0001);
        rd(A_CNT, r); check("R9 count cleared", r, 16'd0);
        check("R9 overflow flag", {15'h0, ovf_flag}, 16'h1);

        // R8 write-only, zero has no effect
        wr(A_EVT, 16'h0047);
        rd(A_EVT, r); check("R8 reads zero", r, 16'h0);
        run_steps(3);
        wr(A_FLG, 16'hFFFF);
        wr(A_EVT, 16'h0000);
        rd(A_CNT, r); check("R8 zero write keeps count", r, 16'd3);
        rd(A_FLG, r); check("R8 zero write keeps flags", r, 16'h0);

        // R10 software channel events set flags
        wr(A_EVT, 16'h0004);
        check("R10 ch1 event flag", {14'h0, ch_flag}, 16'h2);
        wr(A_FLG, 16'h0004);
        check("R12 ch1 flag cleared", {14'h0, ch_flag}, 16'h0);
        wr(A_EVT, 16'h0002);
        check("R10 ch0 event flag", {14'h0, ch_flag}, 16'h1);

        // R11 trigger flag
        wr(A_FLG, 16'hFFFF);
        wr(A_EVT, 16'h0040);
        check("R11 trigger flag", {15'h0, trg_flag}, 16'h1);
        check("R11 no other flags", {13'h0, ch_flag, ovf_flag}, 16'h0);

        // R12 partial clear
        wr(A_EVT, 16'h0001);
        wr(A_FLG, 16'h0040);
        rd(A_FLG, r); check("R12 only trigger cleared", r, 16'h0001);

        // R10 immediate enable drives output
        wr(A_MODE, mbyte(3'd4, 1'b0, 1'b0, 2'b00));
        wr(A_MODE, mbyte(3'd3, 1'b0, 1'b1, 2'b00));
        wr(A_EVT, 16'h0002);
        #1; check("R10 immediate toggle", {15'h0, ch_out[0]}, 16'h1);
        wr(A_MODE, mbyte(3'd3, 1'b0, 1'b0, 2'b00));
        wr(A_EVT, 16'h0002);
        #1; check("R10 no immediate no toggle", {15'h0, ch_out[0]}, 16'h1);

        // R6 input direction
        wr(A_MODE, mbyte(3'd5, 1'b0, 1'b0, 2'b01));
        #1; check("R6 input output low", {15'h0, ch_out[0]}, 16'h0);
        wr(A_C0, 16'd2);
        wr(A_EVT, 16'h0001);
        wr(A_FLG, 16'hFFFF);
        run_steps(4);
        #1; check("R6 input no match flag", {15'h0, ch_flag[0]}, 16'h0);
        wr(A_MODE, mbyte(3'd5, 1'b0, 1'b0, 2'b00));
        wr(A_EVT, 16'h0001);
        wr(A_FLG, 16'hFFFF);
        run_steps(4);
        #1; check("R2 output match flag", {15'h0, ch_flag[0]}, 16'h1);

        // R7 buffered compare
        wr(A_MODE, 16'h0);
        wr(A_C0, 16'd5);
        wr(A_MODE, mbyte(3'd0, 1'b1, 1'b0, 2'b00));
        wr(A_C0, 16'd8);
        rd(A_C0, c0); check("R7 shadow not active", c0, 16'd5);
        wr(A_EVT, 16'h0001);
        rd(A_C0, c0); check("R9 sw overflow loads shadow", c0, 16'd8);
        wr(A_C0, 16'd2);
        rd(A_C0, c0); check("R7 staged again", c0, 16'd8);
        run_steps(10);
        rd(A_C0, c0); check("R7 natural overflow loads", c0, 16'd2);

        finish_run();
    end
endmodule